// File: doc/BRIEF.md
# Two-Real-Spectrum Separator for Paired FFT Bins

A complex FFT can carry two real signals at once: one goes into the real part of each input and the other into the imaginary part. The spectrum that comes out mixes the two. This block takes that spectrum after an earlier stage has placed each pair of partner bins next to each other, and splits it back into a spectrum for signal A and a spectrum for signal B.

Samples arrive as packed complex words with a valid strobe. Every two accepted samples form one pair: the first accepted is the even member and the second is the odd member. Idle cycles do not count. From each pair the block forms one complex result for A and one for B. Each result is a sum or a difference taken one bit wider than the input and then halved. The A result leaves first and the B result second, on a single output stream with its own valid strobe, so the output carries as many samples as the input.

Top module: `spectrum_pair_split`

## Requirements
- R1: Input and output words pack one complex value: bits 15:0 hold the signed real part and bits 31:16 hold the signed imaginary part, both two's complement.
- R2: Pairing counts accepted samples (inVal high) and not clock cycles. Any number of idle cycles, with any data on inDat, may come between the even and odd members or between pairs without changing any result.
- R3: The real part of result A is bits 16:1 of the 17-bit sum odd.re + even.re, which is that sum divided by two and rounded toward minus infinity.
- R4: The imaginary part of result A is bits 16:1 of the 17-bit difference even.im − odd.im.
- R5: The real part of result B is bits 16:1 of the 17-bit sum odd.im + even.im.
- R6: The imaginary part of result B is bits 16:1 of the 17-bit difference odd.re − even.re.
- R7: If the odd member is accepted at clock edge k, result A is on outDat with outVal high in the cycle after edge k. Result B follows with outVal high in the cycle after edge k+1. outVal is low in every other cycle.
- R8: Back-to-back pairs and blocks of 8 samples with 8-cycle gaps produce exactly two outputs per pair, in input order, and the outputs never overlap.
- R9: Synchronous reset clears outVal and forgets any half-received pair. The first accepted sample after reset is always the even member.
- R10: outDat reads all zeros whenever outVal is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inDat | input | 32 | Packed complex input sample {imag, real} |
| inVal | input | 1 | Input sample is accepted on this edge |
| outDat | output | 32 | Packed complex result {imag, real}, A then B |
| outVal | output | 1 | outDat holds a valid result |

## Verification
The pair-phase bit is the only control state that shapes the data, so a slip in it swaps the even and odd members. That flips the sign of the A imaginary and B imaginary outputs and moves the output strobes by one accepted sample, and the error shows on the very next output pair. A wrong rounding or a missing guard bit shows only at the range limits, so the bench sweeps every combination of the extreme and near-zero values over all four input components. It uses varied idle gaps, back-to-back pairs, 8-sample blocks and a reset between the two members of a pair. Every cycle is compared against an expected-output queue keyed by cycle number, so an early, late, missing or extra strobe shows up in the cycle it happens.

// File: rtl/pair_split_pkg.sv
`timescale 1ns/1ps
package pair_split_pkg;

  // Strobes from the control to the datapath, one cycle's worth.
  typedef struct packed {
    logic captureEven;  // accepted sample is the even member
    logic computePair;  // accepted sample is the odd member: form A and B
    logic showA;        // present result A this cycle
    logic showB;        // present result B this cycle
  } splitCtrl_t;

endpackage

// File: rtl/pair_split_halver.sv
`timescale 1ns/1ps
// One lane: a sum or difference taken one bit wide, then halved by
// dropping the least significant bit (floor division by two).
module pair_split_halver #(
  parameter int W        = 16,
  parameter bit SUBTRACT = 1'b0
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] half
);

  logic [W:0] lhsWide;
  logic [W:0] rhsWide;
  logic [W:0] wide;

  assign lhsWide = {lhs[W-1], lhs};
  assign rhsWide = {rhs[W-1], rhs};

  generate
    if (SUBTRACT) begin : gSub
      assign wide = lhsWide - rhsWide;
    end else begin : gAdd
      assign wide = lhsWide + rhsWide;
    end
  endgenerate

  assign half = wide[W:1];

endmodule

// File: rtl/pair_split_ctrl.sv
`timescale 1ns/1ps
module pair_split_ctrl
  import pair_split_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inVal,
  output splitCtrl_t ctrl
);

  logic phaseOdd;   // 1: next accepted sample is the odd member
  logic showAReg;
  logic showBReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseOdd <= 1'b0;
      showAReg <= 1'b0;
      showBReg <= 1'b0;
    end else begin
      if (inVal) phaseOdd <= ~phaseOdd;
      showAReg <= inVal & phaseOdd;
      showBReg <= showAReg;
    end
  end

  assign ctrl.captureEven = inVal & ~phaseOdd;
  assign ctrl.computePair = inVal & phaseOdd;
  assign ctrl.showA       = showAReg;
  assign ctrl.showB       = showBReg;

  AST_IDLE_KEEPS_PHASE: assert property (@(posedge clk) disable iff (rst)
    !inVal |=> $stable(phaseOdd)); // R2
  AST_ACCEPT_FLIPS_PHASE: assert property (@(posedge clk) disable iff (rst)
    inVal |=> (phaseOdd != $past(phaseOdd))); // R2
  AST_A_AFTER_ODD: assert property (@(posedge clk) disable iff (rst)
    (inVal && phaseOdd) |=> showAReg); // R7
  AST_B_AFTER_A: assert property (@(posedge clk) disable iff (rst)
    showAReg |=> showBReg); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({showAReg, showBReg})); // R8

endmodule

// File: rtl/pair_split_dp.sv
`timescale 1ns/1ps
module pair_split_dp
  import pair_split_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*HALF_W-1:0]   inDat,
  input  splitCtrl_t            ctrl,
  output logic [2*HALF_W-1:0]   outDat,
  output logic                  outVal
);

  localparam int WORD_W = 2 * HALF_W;

  logic [WORD_W-1:0] evenReg;
  logic [WORD_W-1:0] resA;
  logic [WORD_W-1:0] resB;

  logic [HALF_W-1:0] evRe, evIm, odRe, odIm;
  logic [HALF_W-1:0] aRe, aIm, bRe, bIm;

  assign evRe = evenReg[HALF_W-1:0];
  assign evIm = evenReg[WORD_W-1:HALF_W];
  assign odRe = inDat[HALF_W-1:0];
  assign odIm = inDat[WORD_W-1:HALF_W];

  pair_split_halver #(.W(HALF_W), .SUBTRACT(1'b0)) i_aRe (.lhs(odRe), .rhs(evRe), .half(aRe));
  pair_split_halver #(.W(HALF_W), .SUBTRACT(1'b1)) i_aIm (.lhs(evIm), .rhs(odIm), .half(aIm));
  pair_split_halver #(.W(HALF_W), .SUBTRACT(1'b0)) i_bRe (.lhs(odIm), .rhs(evIm), .half(bRe));
  pair_split_halver #(.W(HALF_W), .SUBTRACT(1'b1)) i_bIm (.lhs(odRe), .rhs(evRe), .half(bIm));

  always_ff @(posedge clk) begin
    if (rst) begin
      evenReg <= '0;
      resA    <= '0;
      resB    <= '0;
    end else begin
      if (ctrl.captureEven) evenReg <= inDat;
      if (ctrl.computePair) begin
        resA <= {aIm, aRe};
        resB <= {bIm, bRe};
      end
    end
  end

  always_comb begin
    outDat = '0;
    if (ctrl.showA)      outDat = resA;
    else if (ctrl.showB) outDat = resB;
  end

  assign outVal = ctrl.showA | ctrl.showB;

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.computePair |=> ($stable(resA) && $stable(resB))); // R7
  AST_EVEN_HELD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.captureEven |=> $stable(evenReg)); // R2
  AST_B_KEPT_FOR_SHOW: assert property (@(posedge clk) disable iff (rst)
    ctrl.showA |=> $stable(resB)); // R8

endmodule

// File: rtl/spectrum_pair_split.sv
`timescale 1ns/1ps
module spectrum_pair_split
  import pair_split_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*HALF_W-1:0] inDat,
  input  logic                inVal,
  output logic [2*HALF_W-1:0] outDat,
  output logic                outVal
);

  splitCtrl_t ctrl;

  pair_split_ctrl i_ctrl (
    .clk  (clk),
    .rst  (rst),
    .inVal(inVal),
    .ctrl (ctrl)
  );

  pair_split_dp #(.HALF_W(HALF_W)) i_dp (
    .clk   (clk),
    .rst   (rst),
    .inDat (inDat),
    .ctrl  (ctrl),
    .outDat(outDat),
    .outVal(outVal)
  );

endmodule

// File: tb/test_spectrum_pair_split.sv
`timescale 1ns/1ps
module test_spectrum_pair_split;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inVal = 1'b0;
  logic [31:0] inDat = '0;
  logic [31:0] outDat;
  logic        outVal;

  always #10 clk = ~clk;  // 20 ns period: 50 MHz

  spectrum_pair_split #(.HALF_W(16)) i_spectrum_pair_split (
    .clk(clk), .rst(rst), .inDat(inDat), .inVal(inVal),
    .outDat(outDat), .outVal(outVal)
  );

  typedef struct {
    logic [31:0] dat;
    int          at;
    bit          isB;
  } expItem_t;

  expItem_t expQ[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] calcA(logic [31:0] ev, logic [31:0] od);
    int er, ei, oR, oi, re, im;
    er = $signed(ev[15:0]); ei = $signed(ev[31:16]);
    oR = $signed(od[15:0]); oi = $signed(od[31:16]);
    re = (oR + er) >>> 1;   // R3
    im = (ei - oi) >>> 1;   // R4
    return {im[15:0], re[15:0]};
  endfunction

  function automatic logic [31:0] calcB(logic [31:0] ev, logic [31:0] od);
    int er, ei, oR, oi, re, im;
    er = $signed(ev[15:0]); ei = $signed(ev[31:16]);
    oR = $signed(od[15:0]); oi = $signed(od[31:16]);
    re = (oi + ei) >>> 1;   // R5
    im = (oR - er) >>> 1;   // R6
    return {im[15:0], re[15:0]};
  endfunction

  // Monitor: sample half a cycle after each rising edge.
  expItem_t cur;
  always @(negedge clk) begin
    if (!done) begin
      if (expQ.size() > 0 && expQ[0].at == cyc) begin
        cur = expQ.pop_front();
        check(outVal == 1'b1, "R7 outVal", {31'd0, outVal}, 32'd1);
        if (cur.isB) begin
          check(outDat[15:0] == cur.dat[15:0], "R5 B real", outDat, cur.dat);
          check(outDat[31:16] == cur.dat[31:16], "R6 B imag", outDat, cur.dat);
        end else begin
          check(outDat[15:0] == cur.dat[15:0], "R3 A real", outDat, cur.dat);
          check(outDat[31:16] == cur.dat[31:16], "R4 A imag", outDat, cur.dat);
        end
      end else begin
        check(outVal == 1'b0, "R7 idle outVal", {31'd0, outVal}, 32'd0);
        check(outDat == 32'd0, "R10 idle outDat", outDat, 32'd0);
      end
    end
  end

  // All driver tasks are entered at a falling edge and leave at one.
  task automatic putSample(logic [31:0] d);
    inDat = d;
    inVal = 1'b1;
    @(negedge clk);
    inVal = 1'b0;
    inDat = $urandom;   // R2: junk while idle
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendPair(logic [31:0] ev, logic [31:0] od, int midGap);
    putSample(ev);
    idle(midGap);
    expQ.push_back('{dat: calcA(ev, od), at: cyc + 1, isB: 1'b0});
    expQ.push_back('{dat: calcB(ev, od), at: cyc + 2, isB: 1'b1});
    putSample(od);
  endtask

  localparam logic [15:0] CORNER [6] = '{16'h8000, 16'h8001, 16'hFFFF,
                                         16'h0000, 16'h0001, 16'h7FFF};

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    check(outVal == 1'b0, "R9 reset outVal", {31'd0, outVal}, 32'd0);

    // R1 R3-R6: every corner combination of the four components, varied gaps (R2)
    for (int i = 0; i < 1296; i++) begin
      logic [31:0] ev, od;
      ev = {CORNER[(i / 6) % 6], CORNER[i % 6]};
      od = {CORNER[(i / 216) % 6], CORNER[(i / 36) % 6]};
      sendPair(ev, od, i % 3);
      idle((i % 4 == 1) ? 2 : 0);
    end
    idle(4);

    // R9: stray even sample then reset; next pair must start fresh
    putSample(32'h1234_5678);
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    sendPair(32'h0003_FFFD, 32'h7FFF_8000, 0);
    sendPair(32'hFFFF_0001, 32'h0001_FFFF, 5);
    idle(4);

    // R8: blocks of 8 back-to-back samples with 8-cycle gaps
    for (int b = 0; b < 40; b++) begin
      for (int p = 0; p < 4; p++) sendPair($urandom, $urandom, 0);
      idle(8);
    end

    // R2 R8: random pairs, random gaps
    for (int i = 0; i < 2000; i++) begin
      sendPair($urandom, $urandom, $urandom_range(0, 3));
      idle($urandom_range(0, 2));
    end

    idle(6);
    check(expQ.size() == 0, "R8 outputs missing", expQ.size(), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired at cycle %0d actual running expected finished", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule